// File: doc/BRIEF.md
# Sleep Entry and Watchdog Status Controller

This block sits beside the instruction decoder of a small 8-bit core. It watches each fetched instruction word in the first phase of the four-phase instruction cycle. When that word is the sleep opcode, it puts the core into low power at the last phase of the same cycle. At that point it stops the core clock enable, resets the watchdog counter and its postscaler, and sets the time-out and power-down status bits to a fixed pattern.

The watchdog runs all the time on its own tick strobe, which stands in for the independent watchdog clock. A postscaler, selectable as a power of two from 1 to 128, divides that tick before it reaches an 8-bit counter. If the counter overflows while the core sleeps, the core wakes: the block emits a one-cycle wake pulse and clears the time-out bit. An external wake request also restarts the core clock but leaves both status bits as they are, so software can tell the two wake causes apart.

Top module: `sleep_wdt_ctrl`

## Requirements
- R1: During and right after reset, `to_o` = 1, `pd_o` = 1, `core_clk_en_o` = 1, `wdt_count_o` = 0 and `wdt_wake_o` = 0.
- R2: Phase codes on `q_phase_i` are 0 = Q1, 1 = Q2, 2 = Q3 and 3 = Q4. The block samples `instr_i` only in Q1, and only the word 0x0003 selects sleep. A word on `instr_i` in any other phase, or any other word in Q1, has no effect.
- R3: A sleep instruction takes effect at the clock edge that ends its Q4 cycle. From the next cycle on, `core_clk_en_o` = 0, `to_o` = 1, `pd_o` = 0, `wdt_count_o` = 0 and the postscaler is at zero. This clear overrides a tick in the same cycle.
- R4: `wdt_count_o` advances by one for every 2^`wdt_ps_sel_i` ticks of `wdt_tick_i` (select 0..7), whether the core is awake or asleep.
- R5: If a tick takes the counter past 0xFF while the core is asleep, then in the next cycle `wdt_wake_o` is high for exactly one cycle, `core_clk_en_o` = 1, `to_o` = 0, `pd_o` = 0 and the counter reads 0.
- R6: `wake_i` high while asleep, with no overflow in that cycle, gives `core_clk_en_o` = 1 in the next cycle. `to_o` and `pd_o` stay as they were, no wake pulse is emitted, and the counter is not reset.
- R7: While awake, a counter overflow only wraps the counter to 0: no wake pulse, and the status bits are unchanged. `wake_i` while awake has no effect.
- R8: If an overflow and `wake_i` arrive in the same cycle while asleep, the block handles the wake as a watchdog wake (R5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running system clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| instr_i | input | 16 | Fetched instruction word |
| q_phase_i | input | 2 | Instruction-cycle phase, 0..3 = Q1..Q4 |
| wdt_tick_i | input | 1 | Watchdog time-base tick strobe |
| wdt_ps_sel_i | input | 3 | Postscaler select, divide by 2^value |
| wake_i | input | 1 | External wake request |
| core_clk_en_o | output | 1 | Core clock enable, low while asleep |
| to_o | output | 1 | Time-out status bit |
| pd_o | output | 1 | Power-down status bit |
| wdt_wake_o | output | 1 | One-cycle pulse on a watchdog wake |
| wdt_count_o | output | 8 | Watchdog counter value |

## Verification
Every output comes from a register, so each result appears one edge after the input that causes it. The status pattern of a sleep entry shows up in the cycle after the Q4 edge. A tick or wake request applied before an edge shows up on the counter, the status bits and the wake pulse right after that edge. The bench drives inputs on the falling edge and samples after the next rising edge has settled, so every comparison lands in the cycle in which the result is due. The watchdog sweep checks the counter after every tick, for every postscaler setting, up to and including the overflow cycle and the cycle after it.

// File: rtl/sleep_wdt_pkg.sv
package sleep_wdt_pkg;
  typedef enum logic [1:0] {
    PH_Q1 = 2'd0,
    PH_Q2 = 2'd1,
    PH_Q3 = 2'd2,
    PH_Q4 = 2'd3
  } qphase_e;
endpackage

// File: rtl/sleep_decode.sv
module sleep_decode
  import sleep_wdt_pkg::*;
#(
  parameter int unsigned      INSTR_W  = 16,
  parameter logic [INSTR_W-1:0] SLEEP_OP = 16'h0003
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [1:0]         phase_i,
  output logic               enter_o
);
  qphase_e ph;
  logic    pending_q;

  assign ph = qphase_e'(phase_i);

  // opcode captured in Q1, acted on in Q4
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q <= 1'b0;
    end else if (run_i) begin
      case (ph)
        PH_Q1:   pending_q <= (instr_i == SLEEP_OP);
        PH_Q4:   pending_q <= 1'b0;
        default: pending_q <= pending_q;
      endcase
    end
  end

  assign enter_o = run_i && pending_q && (ph == PH_Q4);
endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned PS_STAGES = 7,
  parameter int unsigned SEL_W     = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             tick_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  logic [PS_STAGES-1:0] ps_q;
  logic [PS_STAGES-1:0] ps_mask;
  logic [CNT_W-1:0]     cnt_q;
  logic                 ps_done;
  logic                 step;

  // bits of the postscaler that take part at this select value
  for (genvar gi = 0; gi < PS_STAGES; gi++) begin : g_mask
    assign ps_mask[gi] = (sel_i > SEL_W'(gi));
  end

  assign ps_done = &(ps_q | ~ps_mask);
  assign step    = tick_i && ps_done;
  assign ovf_o   = step && (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ps_q  <= '0;
      cnt_q <= '0;
    end else if (clear_i) begin
      ps_q  <= '0;
      cnt_q <= '0;
    end else if (tick_i) begin
      ps_q <= ps_done ? '0 : ps_q + PS_STAGES'(1);
      if (step) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/power_state.sv
module power_state (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enter_i,
  input  logic ovf_i,
  input  logic ext_wake_i,
  output logic asleep_o,
  output logic to_o,
  output logic pd_o,
  output logic wdt_wake_o
);
  logic asleep_q, to_q, pd_q, wake_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      asleep_q <= 1'b0;
      to_q     <= 1'b1;
      pd_q     <= 1'b1;
      wake_q   <= 1'b0;
    end else begin
      wake_q <= 1'b0;
      if (enter_i) begin
        asleep_q <= 1'b1;
        to_q     <= 1'b1;
        pd_q     <= 1'b0;
      end else if (asleep_q && ovf_i) begin
        // watchdog wake wins over a coincident external request
        asleep_q <= 1'b0;
        to_q     <= 1'b0;
        wake_q   <= 1'b1;
      end else if (asleep_q && ext_wake_i) begin
        asleep_q <= 1'b0;
      end
    end
  end

  assign asleep_o   = asleep_q;
  assign to_o       = to_q;
  assign pd_o       = pd_q;
  assign wdt_wake_o = wake_q;
endmodule

// File: rtl/sleep_wdt_ctrl.sv
module sleep_wdt_ctrl #(
  parameter int unsigned INSTR_W   = 16,
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned PS_STAGES = 7,
  parameter int unsigned PS_SEL_W  = $clog2(PS_STAGES + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [INSTR_W-1:0]  instr_i,
  input  logic [1:0]          q_phase_i,
  input  logic                wdt_tick_i,
  input  logic [PS_SEL_W-1:0] wdt_ps_sel_i,
  input  logic                wake_i,
  output logic                core_clk_en_o,
  output logic                to_o,
  output logic                pd_o,
  output logic                wdt_wake_o,
  output logic [CNT_W-1:0]    wdt_count_o
);
  localparam logic [INSTR_W-1:0] SLEEP_OP = INSTR_W'(3);

  logic asleep;
  logic sleep_enter;
  logic wdt_ovf;

  sleep_decode #(
    .INSTR_W (INSTR_W),
    .SLEEP_OP(SLEEP_OP)
  ) u_dec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (!asleep),
    .instr_i(instr_i),
    .phase_i(q_phase_i),
    .enter_o(sleep_enter)
  );

  wdt_core #(
    .CNT_W    (CNT_W),
    .PS_STAGES(PS_STAGES),
    .SEL_W    (PS_SEL_W)
  ) u_wdt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(sleep_enter),
    .tick_i (wdt_tick_i),
    .sel_i  (wdt_ps_sel_i),
    .cnt_o  (wdt_count_o),
    .ovf_o  (wdt_ovf)
  );

  power_state u_pwr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .enter_i   (sleep_enter),
    .ovf_i     (wdt_ovf),
    .ext_wake_i(wake_i),
    .asleep_o  (asleep),
    .to_o      (to_o),
    .pd_o      (pd_o),
    .wdt_wake_o(wdt_wake_o)
  );

  assign core_clk_en_o = !asleep;
endmodule

// File: rtl/sleep_wdt_chk.sv
module sleep_wdt_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             enter_i,
  input logic             ovf_i,
  input logic             ext_wake_i,
  input logic             clk_en_i,
  input logic             to_i,
  input logic             pd_i,
  input logic             wake_i,
  input logic [CNT_W-1:0] cnt_i
);
  a_r3_entry_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enter_i |=> (!clk_en_i && to_i && !pd_i && cnt_i == '0));

  a_r3_pd_low_asleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en_i |-> !pd_i);

  a_r4_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (cnt_i == $past(cnt_i) || cnt_i == $past(cnt_i) + CNT_W'(1) || cnt_i == '0));

  a_r5_pulse_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_i |=> !wake_i);

  a_r5_pulse_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_i |-> (clk_en_i && !to_i && !pd_i && cnt_i == '0));

  a_r6_ext_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_en_i && ext_wake_i && !ovf_i) |=> (clk_en_i && $stable(to_i) && $stable(pd_i) && !wake_i));

  a_r7_no_pulse_awake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_i |=> !wake_i);

  a_r8_ovf_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_en_i && ovf_i && ext_wake_i) |=> (wake_i && !to_i));
endmodule

bind sleep_wdt_ctrl sleep_wdt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .enter_i   (sleep_enter),
  .ovf_i     (wdt_ovf),
  .ext_wake_i(wake_i),
  .clk_en_i  (core_clk_en_o),
  .to_i      (to_o),
  .pd_i      (pd_o),
  .wake_i    (wdt_wake_o),
  .cnt_i     (wdt_count_o)
);

// File: tb/sim_sleep_wdt_ctrl.sv
module sim_sleep_wdt_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] instr = '0;
  logic [1:0]  phase = 2'd1;
  logic        tick = 1'b0;
  logic [2:0]  sel = '0;
  logic        wake = 1'b0;
  logic        clk_en, to, pd, wdt_wake;
  logic [7:0]  count;
  int unsigned n_vec = 0;
  int unsigned n_bad = 0;

  always #10 clk = ~clk;

  sleep_wdt_ctrl u0 (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .instr_i      (instr),
    .q_phase_i    (phase),
    .wdt_tick_i   (tick),
    .wdt_ps_sel_i (sel),
    .wake_i       (wake),
    .core_clk_en_o(clk_en),
    .to_o         (to),
    .pd_o         (pd),
    .wdt_wake_o   (wdt_wake),
    .wdt_count_o  (count)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  // one instruction cycle: q1_word in Q1, other_word in Q2..Q4
  task automatic run_instr(input logic [15:0] q1_word, input logic [15:0] other_word);
    for (int p = 0; p < 4; p++) begin
      instr = (p == 0) ? q1_word : other_word;
      phase = 2'(p);
      cyc();
    end
    phase = 2'd1;
    instr = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 to", 32'(to), 1);
    check("R1 pd", 32'(pd), 1);
    check("R1 clk_en", 32'(clk_en), 1);
    check("R1 count", 32'(count), 0);
    check("R1 wake", 32'(wdt_wake), 0);
    rst_n = 1'b1;
    cyc();
    check("R1 to after release", 32'(to), 1);

    // R2: opcode outside Q1, or a different word in Q1, does nothing
    run_instr(16'h0004, 16'h0003);
    check("R2 non-Q1 opcode clk_en", 32'(clk_en), 1);
    check("R2 non-Q1 opcode pd", 32'(pd), 1);
    run_instr(16'h0103, 16'h0003);
    check("R2 other word clk_en", 32'(clk_en), 1);

    // R7: overflow while awake
    sel  = 3'd0;
    tick = 1'b1;
    for (int n = 1; n <= 256; n++) begin
      cyc();
      check("R7 no pulse awake", 32'(wdt_wake), 0);
      check("R4 awake count", 32'(count), 32'(n % 256));
    end
    tick = 1'b0;
    check("R7 to kept", 32'(to), 1);
    check("R7 pd kept", 32'(pd), 1);
    wake = 1'b1;
    cyc();
    wake = 1'b0;
    check("R7 wake ignored clk_en", 32'(clk_en), 1);
    check("R7 wake ignored pd", 32'(pd), 1);

    // R3: entry clears counter and postscaler
    sel  = 3'd2;
    tick = 1'b1;
    repeat (7) cyc();
    tick = 1'b0;
    check("R4 pre-sleep count", 32'(count), 1);
    run_instr(16'h0003, 16'h1234);
    check("R3 clk_en", 32'(clk_en), 0);
    check("R3 to", 32'(to), 1);
    check("R3 pd", 32'(pd), 0);
    check("R3 count", 32'(count), 0);
    tick = 1'b1;
    for (int n = 1; n <= 4; n++) begin
      cyc();
      check("R3 postscaler cleared", 32'(count), (n == 4) ? 1 : 0);
    end
    tick = 1'b0;

    // R6: external wake while asleep
    wake = 1'b1;
    cyc();
    wake = 1'b0;
    check("R6 clk_en", 32'(clk_en), 1);
    check("R6 to", 32'(to), 1);
    check("R6 pd", 32'(pd), 0);
    check("R6 no pulse", 32'(wdt_wake), 0);
    check("R6 count kept", 32'(count), 1);

    // R4/R5: sleep then watchdog wake, all postscaler settings
    for (int s = 0; s < 8; s++) begin
      sel = 3'(s);
      run_instr(16'h0003, 16'h0000);
      check("R3 entry to", 32'(to), 1);
      check("R3 entry clk_en", 32'(clk_en), 0);
      tick = 1'b1;
      for (int n = 1; n <= (256 << s); n++) begin
        cyc();
        if (n < (256 << s)) begin
          check("R4 count", 32'(count), 32'(n >> s));
          check("R5 no early pulse", 32'(wdt_wake), 0);
        end else begin
          check("R5 pulse", 32'(wdt_wake), 1);
          check("R5 clk_en", 32'(clk_en), 1);
          check("R5 to", 32'(to), 0);
          check("R5 pd", 32'(pd), 0);
          check("R5 count wrap", 32'(count), 0);
        end
      end
      tick = 1'b0;
      cyc();
      check("R5 pulse width", 32'(wdt_wake), 0);
    end

    // R8: overflow and external wake together
    sel = 3'd0;
    run_instr(16'h0003, 16'h0000);
    tick = 1'b1;
    repeat (255) cyc();
    check("R8 pre count", 32'(count), 255);
    wake = 1'b1;
    cyc();
    wake = 1'b0;
    tick = 1'b0;
    check("R8 pulse", 32'(wdt_wake), 1);
    check("R8 to", 32'(to), 0);
    check("R8 clk_en", 32'(clk_en), 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule